// File: doc/BRIEF.md
# Transmit Symbol FIFO with Sticky Status

This block buffers I/Q symbols between a serial symbol source and a transmit filter channel. It holds up to seven symbols. Its fill level is a 3-bit count, where 0 means empty and 7 means full. The filter pops symbols with a read strobe. The head symbol is presented combinationally, so the data seen in the same cycle as the strobe is the symbol being consumed.

Around the queue the block keeps a 16-bit status word. The level field and the empty and almost-empty bits are live. The event bits are sticky: FIFO overflow, FIFO underflow, the four filter saturation events and channel-flushed. Sticky bits stay set until a clear strobe arrives.

When the queue first becomes full, the block raises an off-line request and the channel goes off-line. While the channel is off-line, reads return zeros and incoming symbols are dropped. Once the on-line control bit drops, the block counts reads. The 24th read sets the flushed bit. A rising edge on the on-line bit withdraws the off-line request.

Top module: `txsym_fifo_status`

## Requirements
- R1: Every input is sampled at a clock edge. A write is accepted when the level is below 7 and the channel is on-line. A read is accepted when the level is above 0. The level at status[6:4] equals accepted writes minus accepted reads, and it updates at the edge that samples the strobes.
- R2: While on-line with a level above 0, rd_i/rd_q show the oldest stored symbol (first in, first out). With a level of 0 they are zero.
- R3: A write while the level is 7 is dropped: the level stays 7 and the stored symbols read back later are unchanged.
- R4: status[0] (empty) is 1 exactly when the level is 0. status[1] (almost empty) is 1 exactly when the level is below ae_thresh. Both follow the registered level.
- R5: At the edge after the level first reaches 7, sticky status[2] (FIFO overflow) sets and offline_req rises. offline_req rises only when the level goes from below 7 to 7.
- R6: A cycle with rd_en=1, wr_en=0 and a level of 0 sets sticky status[3] (FIFO underflow) at the next edge.
- R7: Saturation pulses set sticky bits at the next edge: I most-positive sets status[10], I most-negative sets status[9], Q most-positive sets status[8], and Q most-negative sets status[7].
- R8: The channel is off-line while online=0 or offline_req=1. While off-line, rd_i/rd_q are zero and writes are dropped, but reads still pop the queue.
- R9: While online=0, reads are counted. The edge that samples the 24th such read sets sticky status[11] (flushed). While online=1 the count is held at zero.
- R10: At the edge after a cycle in which online is 1 and was 0 in the previous sampled cycle, offline_req clears. A new overflow in that same cycle takes priority. The flushed bit is not affected.
- R11: clr_status=1 clears every sticky bit at the next edge. A set event in the same cycle still sets its bit. status[15:12] is always 0.
- R12: err_any is the OR of status bits 10, 9, 8, 7 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Symbol write strobe |
| wr_i | input | 16 | I symbol to store |
| wr_q | input | 16 | Q symbol to store |
| rd_en | input | 1 | Read strobe from the filter |
| online | input | 1 | Channel on-line control bit |
| ae_thresh | input | 3 | Almost-empty threshold |
| i_sat_pos | input | 1 | I accumulator clamped to most positive |
| i_sat_neg | input | 1 | I accumulator clamped to most negative plus one |
| q_sat_pos | input | 1 | Q accumulator clamped to most positive |
| q_sat_neg | input | 1 | Q accumulator clamped to most negative plus one |
| clr_status | input | 1 | Clears the sticky status bits |
| rd_i | output | 16 | Head I symbol, zero when empty or off-line |
| rd_q | output | 16 | Head Q symbol, zero when empty or off-line |
| status | output | 16 | Status word |
| err_any | output | 1 | Summary of the error sticky bits |
| offline_req | output | 1 | Off-line request raised by overflow |

## Verification
Read data is combinational, so the bench compares rd_i/rd_q one time unit after driving the inputs, within the same cycle. The level, all sticky bits, offline_req and err_any are registered and are due one edge after the stimulus that causes them. The almost-empty bit is the one exception: it responds at once to a change of threshold.

Each step of the bench drives inputs at the falling edge and compares every output against the model's current state. Only then does it advance the model by one edge. As a result, each registered result is compared exactly one cycle after its cause.

Specific cycle positions are pinned by directed sequences. One checks that offline_req rises two edges after the seventh write. Another checks that the flushed bit appears right after the 24th off-line read and not after the 23rd.

// File: rtl/txsym_pkg.sv
package txsym_pkg;

    // Sticky event bits of the status word
    typedef struct packed {
        logic flushed;
        logic i_pos;
        logic i_neg;
        logic q_pos;
        logic q_neg;
        logic fifo_unf;
        logic fifo_ovf;
    } sticky_t;

    localparam int STATUS_W = 16;

endpackage

// File: rtl/txsym_store.sv
module txsym_store #(
    parameter int DW = 16,
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] in_i,
    input  logic [DW-1:0] in_q,
    output logic [DW-1:0] head_i,
    output logic [DW-1:0] head_q,
    output logic [LW-1:0] level
);
    localparam int DEPTH = 1 << LW;
    localparam logic [LW-1:0] FULL = '1;

    typedef struct packed {
        logic [LW-1:0] wp;
        logic [LW-1:0] rp;
        logic [LW-1:0] lvl;
    } ptr_t;

    ptr_t s_q, s_d;
    logic [2*DW-1:0] mem_q [DEPTH];
    logic [2*DW-1:0] mem_d [DEPTH];
    logic w_ok, r_ok;

    always_comb begin
        w_ok = push && (s_q.lvl != FULL);
        r_ok = pop && (s_q.lvl != '0);
        s_d  = s_q;
        for (int k = 0; k < DEPTH; k++) mem_d[k] = mem_q[k];
        if (w_ok) begin
            mem_d[s_q.wp] = {in_i, in_q};
            s_d.wp = s_q.wp + 1'b1;
        end
        if (r_ok) s_d.rp = s_q.rp + 1'b1;
        case ({w_ok, r_ok})
            2'b10:   s_d.lvl = s_q.lvl + 1'b1;
            2'b01:   s_d.lvl = s_q.lvl - 1'b1;
            default: s_d.lvl = s_q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
        end else begin
            s_q <= s_d;
            for (int k = 0; k < DEPTH; k++) mem_q[k] <= mem_d[k];
        end
    end

    assign {head_i, head_q} = mem_q[s_q.rp];
    assign level            = s_q.lvl;

    // R1
    level_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && level != FULL) |=> (int'(level) == int'($past(level)) + 1));

    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && level == FULL) |=> (level == FULL));

endmodule

// File: rtl/txsym_flush.sv
module txsym_flush #(
    parameter int FLUSH_N = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic online,
    input  logic rd_en,
    output logic done
);
    localparam int CW = $clog2(FLUSH_N + 1);
    localparam logic [CW-1:0] LAST = CW'(FLUSH_N - 1);
    localparam logic [CW-1:0] SAT  = CW'(FLUSH_N);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } fl_t;

    fl_t f_q, f_d;

    always_comb begin
        f_d  = f_q;
        done = 1'b0;
        if (online) begin
            f_d.cnt = '0;
        end else if (rd_en && f_q.cnt != SAT) begin
            f_d.cnt = f_q.cnt + 1'b1;
            done    = (f_q.cnt == LAST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        online |=> (f_q.cnt == '0));

endmodule

// File: rtl/txsym_fifo_status.sv
module txsym_fifo_status #(
    parameter int DW      = 16,
    parameter int LW      = 3,
    parameter int FLUSH_N = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_i,
    input  logic [DW-1:0] wr_q,
    input  logic          rd_en,
    input  logic          online,
    input  logic [LW-1:0] ae_thresh,
    input  logic          i_sat_pos,
    input  logic          i_sat_neg,
    input  logic          q_sat_pos,
    input  logic          q_sat_neg,
    input  logic          clr_status,
    output logic [DW-1:0] rd_i,
    output logic [DW-1:0] rd_q,
    output logic [15:0]   status,
    output logic          err_any,
    output logic          offline_req
);
    import txsym_pkg::*;

    localparam logic [LW-1:0] FULL = '1;

    typedef struct packed {
        sticky_t stk;
        logic    offreq;
        logic    online_p;
        logic    full_p;
    } top_t;

    top_t t_q, t_d;
    logic [LW-1:0] level;
    logic [DW-1:0] head_i, head_q;
    logic          flush_done;
    logic          off_line, push, full, rise;

    assign off_line = !online || t_q.offreq;
    assign push     = wr_en && !off_line;
    assign full     = (level == FULL);
    assign rise     = online && !t_q.online_p;

    txsym_store #(.DW(DW), .LW(LW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .pop    (rd_en),
        .in_i   (wr_i),
        .in_q   (wr_q),
        .head_i (head_i),
        .head_q (head_q),
        .level  (level)
    );

    txsym_flush #(.FLUSH_N(FLUSH_N)) u_flush (
        .clk    (clk),
        .rst_n  (rst_n),
        .online (online),
        .rd_en  (rd_en),
        .done   (flush_done)
    );

    always_comb begin
        t_d          = t_q;
        t_d.stk      = clr_status ? '0 : t_q.stk;
        t_d.stk.flushed  = t_d.stk.flushed  | flush_done;
        t_d.stk.i_pos    = t_d.stk.i_pos    | i_sat_pos;
        t_d.stk.i_neg    = t_d.stk.i_neg    | i_sat_neg;
        t_d.stk.q_pos    = t_d.stk.q_pos    | q_sat_pos;
        t_d.stk.q_neg    = t_d.stk.q_neg    | q_sat_neg;
        t_d.stk.fifo_unf = t_d.stk.fifo_unf | (rd_en && !wr_en && level == '0);
        t_d.stk.fifo_ovf = t_d.stk.fifo_ovf | full;
        t_d.offreq   = (full && !t_q.full_p) || (t_q.offreq && !rise);
        t_d.online_p = online;
        t_d.full_p   = full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    always_comb begin
        if (off_line || level == '0) begin
            rd_i = '0;
            rd_q = '0;
        end else begin
            rd_i = head_i;
            rd_q = head_q;
        end
    end

    assign status = {4'b0000, t_q.stk.flushed,
                     t_q.stk.i_pos, t_q.stk.i_neg, t_q.stk.q_pos, t_q.stk.q_neg,
                     level, t_q.stk.fifo_unf, t_q.stk.fifo_ovf,
                     (level < ae_thresh), (level == '0)};
    assign err_any = t_q.stk.i_pos | t_q.stk.i_neg | t_q.stk.q_pos |
                     t_q.stk.q_neg | t_q.stk.fifo_unf;
    assign offline_req = t_q.offreq;

    // R5
    full_offline_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !t_q.full_p) |=> (offline_req && status[2]));

    // R6
    unf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && level == '0) |=> status[3]);

    // R8
    offline_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !online |-> (rd_i == '0 && rd_q == '0));

    // R10
    rise_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !(full && !t_q.full_p)) |=> !offline_req);

    // R11
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[10] && !clr_status) |=> status[10]);

endmodule

// File: tb/sim_txsym_fifo_status.sv
module sim_txsym_fifo_status;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, online = 1'b1, clr_status = 1'b0;
    logic [15:0] wr_i = '0, wr_q = '0;
    logic [2:0]  ae_thresh = 3'd2;
    logic        i_sat_pos = 1'b0, i_sat_neg = 1'b0, q_sat_pos = 1'b0, q_sat_neg = 1'b0;
    logic [15:0] rd_i, rd_q, status;
    logic        err_any, offline_req;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [31:0] mq[$];
    int          m_lvl = 0;
    logic [6:0]  m_stk = '0;   // {flushed,ipos,ineg,qpos,qneg,unf,ovf}
    logic        m_off = 1'b0, m_onp = 1'b0, m_fullp = 1'b0;
    int          m_cnt = 0;
    logic [31:0] got;

    always #10 clk = ~clk;

    txsym_fifo_status u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_i(wr_i), .wr_q(wr_q),
        .rd_en(rd_en), .online(online), .ae_thresh(ae_thresh),
        .i_sat_pos(i_sat_pos), .i_sat_neg(i_sat_neg),
        .q_sat_pos(q_sat_pos), .q_sat_neg(q_sat_neg),
        .clr_status(clr_status), .rd_i(rd_i), .rd_q(rd_q),
        .status(status), .err_any(err_any), .offline_req(offline_req)
    );

    function automatic logic [1:0] live_flags(input int lvl, input logic [2:0] thr);
        return {(lvl < int'(thr)), (lvl == 0)};
    endfunction

    function automatic logic err_of(input logic [6:0] s);
        return s[5] | s[4] | s[3] | s[2] | s[1];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [15:0] wi, input logic [15:0] wq,
                        input logic rd, input logic on, input logic [2:0] thr,
                        input logic [3:0] sat, input logic clr);
        logic        off, racc, wacc, full;
        logic [31:0] exp_d;
        logic [6:0]  nst;
        wr_en = wr; wr_i = wi; wr_q = wq; rd_en = rd; online = on; ae_thresh = thr;
        {i_sat_pos, i_sat_neg, q_sat_pos, q_sat_neg} = sat; clr_status = clr;
        #1;
        off   = !on || m_off;
        exp_d = (off || m_lvl == 0) ? 32'h0 : mq[0];
        got   = {rd_i, rd_q};
        if (off) chk("R8 read data", got, exp_d);
        else     chk("R2 read data", got, exp_d);
        chk("R1 level", 32'(status[6:4]), 32'(m_lvl));
        chk("R4 live flags", 32'(status[1:0]), 32'(live_flags(m_lvl, thr)));
        chk("R5 overflow bit", 32'(status[2]), 32'(m_stk[0]));
        chk("R6 underflow bit", 32'(status[3]), 32'(m_stk[1]));
        chk("R7 saturation bits", 32'(status[10:7]), 32'(m_stk[5:2]));
        chk("R9 flushed bit", 32'(status[11]), 32'(m_stk[6]));
        chk("R11 upper bits", 32'(status[15:12]), 32'h0);
        chk("R10 offline_req", 32'(offline_req), 32'(m_off));
        chk("R12 err_any", 32'(err_any), 32'(err_of(m_stk)));
        // advance model by one edge
        full = (m_lvl == 7);
        racc = rd && m_lvl > 0;
        wacc = wr && !off && m_lvl < 7;
        nst = clr ? 7'b0 : m_stk;
        nst[6] |= (!on && rd && m_cnt == 23);
        nst[5:2] |= sat;
        nst[1] |= (rd && !wr && m_lvl == 0);
        nst[0] |= full;
        m_stk = nst;
        m_off = (full && !m_fullp) || (m_off && !(on && !m_onp));
        m_onp = on;
        m_fullp = full;
        if (on) m_cnt = 0;
        else if (rd && m_cnt < 24) m_cnt++;
        if (racc) void'(mq.pop_front());
        if (wacc) mq.push_back({wi, wq});
        m_lvl = m_lvl + int'(wacc) - int'(racc);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog expired: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic ph;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        step(0, 0, 0, 0, 1, 3'd2, 4'b0, 0);

        // R3: fill to 7, one extra write dropped, then recover and read back
        for (int k = 0; k < 7; k++) step(1, 16'h100 + 16'(k), 16'h200 + 16'(k), 0, 1, 3'd2, 4'b0, 0);
        step(1, 16'hDEAD, 16'hBEEF, 0, 1, 3'd2, 4'b0, 0);
        chk("R5 offline_req after fill", 32'(offline_req), 32'h1);
        step(0, 0, 0, 0, 0, 3'd2, 4'b0, 0);
        step(0, 0, 0, 0, 1, 3'd2, 4'b0, 0);
        for (int k = 0; k < 7; k++) begin
            step(0, 0, 0, 1, 1, 3'd2, 4'b0, 0);
            chk("R3 stored data intact", got, {16'h100 + 16'(k), 16'h200 + 16'(k)});
        end

        // R6: read while empty
        step(0, 0, 0, 1, 1, 3'd7, 4'b0, 0);
        // R7: each saturation pulse
        step(0, 0, 0, 0, 1, 3'd0, 4'b1000, 0);
        step(0, 0, 0, 0, 1, 3'd0, 4'b0101, 0);
        // R11: clear with simultaneous set event
        step(0, 0, 0, 0, 1, 3'd0, 4'b0010, 1);
        chk("R11 set wins over clear", 32'(status[8]), 32'h1);
        step(0, 0, 0, 0, 1, 3'd0, 4'b0, 1);

        // R9: 23 off-line reads, then the 24th
        for (int k = 0; k < 23; k++) step(0, 0, 0, 1, 0, 3'd1, 4'b0, 0);
        step(0, 0, 0, 0, 0, 3'd1, 4'b0, 0);
        chk("R9 not yet flushed", 32'(status[11]), 32'h0);
        step(0, 0, 0, 1, 0, 3'd1, 4'b0, 0);
        chk("R9 flushed after 24th read", 32'(status[11]), 32'h1);
        // R10: back on-line, flushed stays
        step(0, 0, 0, 0, 1, 3'd1, 4'b0, 0);
        step(0, 0, 0, 0, 1, 3'd1, 4'b0, 0);
        chk("R10 flushed kept", 32'(status[11]), 32'h1);
        step(0, 0, 0, 0, 1, 3'd1, 4'b0, 1);

        // random phase
        ph = 1'b1;
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] s;
            if ($urandom_range(63) == 0) ph = !ph;
            s[3] = ($urandom_range(31) == 0);
            s[2] = ($urandom_range(31) == 0);
            s[1] = ($urandom_range(31) == 0);
            s[0] = ($urandom_range(31) == 0);
            step(($urandom_range(99) < 60), 16'($urandom), 16'($urandom),
                 ($urandom_range(99) < 45), ph, 3'($urandom_range(7)), s,
                 ($urandom_range(15) == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule